// File: doc/BRIEF.md
# Multiplexed LCD Frame Sequencer with Fetch-End Interrupt

This block drives the timing side of a multiplexed LCD. A programmable prescaler divides the input clock into ticks. A phase counter then walks through one, two, three or four common periods per frame, chosen by a 2-bit duty field. For each common line it emits a 2-bit drive-level code. It also marks the start of each frame and shows when the display controller is reading pixel data for the next frame.

Software, or an external segment driver, updates pixel data in step with the display by means of a sticky interrupt flag. The flag sets when the controller finishes reading a frame's data. That point lies in the middle of the last common period, half a common period before the frame boundary. A write-allowed status stays high from that point until the next read begins, half a common period into the next frame. The safe window is therefore one common period long in every duty setting. A new duty setting is taken only as a new frame starts.

Top module: `lcd_frame_timer`

## Requirements
- R1: The duty field `duty_sel` sets the number of commons per frame to `duty_sel`+1: 0 is static, 1 is 1/2, 2 is 1/3 and 3 is 1/4 duty. A frame lasts (`duty_sel`+1)·`TICKS_PER_COM` ticks. `frame_start` pulses for exactly one clock in the first clock of common 0.
- R2: One tick lasts `prescale`+1 clocks, so a frame lasts (`duty_sel`+1)·`TICKS_PER_COM`·(`prescale`+1) clocks.
- R3: `com_level` holds one 2-bit code per common, with common k in bits [2k+1:2k]. Code 0 means ground, 1 means 1/3, 2 means 2/3 and 3 means full supply. The selected common is at 3 in the first half of its period and at 0 in the second half. The other active commons are at 1 in the first half and at 2 in the second half. Commons above the duty setting are at 0.
- R4: `irq_flag` rises one clock after the read window ends, at clock offset ((`duty_sel`)·T + T/2)·(`prescale`+1) + 1 from `frame_start`, where T is `TICKS_PER_COM`.
- R5: For duty settings 1 to 3, `write_ok` rises one clock before `irq_flag` and stays high for T·(`prescale`+1) clocks. `fetch_active` is its complement while enabled. In static duty `write_ok` stays high.
- R6: `irq_flag` is sticky. A one-clock high on `irq_clr` clears it on the next clock. A clear in the same clock as a new set leaves it set.
- R7: A change of `duty_sel` in mid-frame does not alter the current frame. It takes effect from the next frame boundary.
- R8: While `run_en` is low the counters are held at frame start. In that state `com_level` is 0, `write_ok` is 1, `fetch_active` and `frame_start` are 0, and `irq_flag` keeps its value. Raising `run_en` starts a frame in that same clock.
- R9: After reset `irq_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low holds the sequencer idle at frame start |
| duty_sel | input | 2 | Duty setting: number of commons minus one |
| prescale | input | PRE_W | Tick divider: a tick lasts prescale+1 clocks |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| frame_start | output | 1 | One-clock pulse at the leading edge of common 0 |
| com_level | output | 8 | Four 2-bit drive-level codes, common 0 in the low bits |
| fetch_active | output | 1 | High while the controller reads pixel data |
| write_ok | output | 1 | High while pixel data may be changed safely |
| irq_flag | output | 1 | Sticky frame interrupt flag |

## Verification
The embedded assertions check the following on every clock:
- the flag's set, clear and set-wins rules, and that the flag is set one clock after each end of the read window;
- that the common index stays inside the active duty and that the duty setting changes only at a frame boundary;
- that exactly one common sits at full-supply level in each first half-period;
- the idle outputs while disabled.

The exact clock positions of the interrupt and of the window edges, the frame lengths for each duty and prescale pairing, and the drive-level patterns can only be shown by the bench's scenarios. The same holds for the deferral of a duty change to the next frame and for the set-wins case, which the bench provokes by placing the clear strobe in the clock of the set.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;

    // number of common lines the 2-bit duty field can address
    localparam int unsigned NCOM = 4;

    // drive-level codes, fraction of supply in thirds
    typedef enum logic [1:0] {
        LV_GND   = 2'd0,
        LV_THIRD = 2'd1,
        LV_TWO3  = 2'd2,
        LV_FULL  = 2'd3
    } lvl_e;

endpackage

// File: rtl/lcdf_prescaler.sv
module lcdf_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             tick,
    output logic             phase0
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick   = run && (st_q.cnt >= limit);
        phase0 = (st_q.cnt == '0);
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: each tick starts a fresh divider period
    a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> phase0);

    // R8: an idle divider stays at its start
    a_r8_idle_divider: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> phase0);

endmodule

// File: rtl/lcdf_sequencer.sv
module lcdf_sequencer #(
    parameter int unsigned TICKS_PER_COM = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       phase0,
    input  logic [1:0] duty_sel,
    output logic [1:0] com_idx,
    output logic [1:0] duty_act,
    output logic       second_half,
    output logic       frame_start,
    output logic       irq_set,
    output logic       fetch_active
);

    localparam int unsigned TW   = (TICKS_PER_COM > 1) ? $clog2(TICKS_PER_COM) : 1;
    localparam int unsigned HALF = TICKS_PER_COM / 2;
    localparam logic [TW-1:0] TK_LAST = TW'(TICKS_PER_COM - 1);
    localparam logic [TW-1:0] TK_HALF = TW'(HALF);

    typedef struct packed {
        logic [1:0]    com;
        logic [TW-1:0] tk;
        logic [1:0]    duty;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    at_last_com;
    logic    in_first_edge;
    logic    in_last_edge;

    always_comb begin
        st_d        = st_q;
        at_last_com = (st_q.com == st_q.duty);
        if (!run) begin
            st_d.com  = '0;
            st_d.tk   = '0;
            st_d.duty = duty_sel;
        end else if (tick) begin
            if (st_q.tk == TK_LAST) begin
                st_d.tk = '0;
                if (at_last_com) begin
                    st_d.com  = '0;
                    st_d.duty = duty_sel;
                end else begin
                    st_d.com = st_q.com + 2'd1;
                end
            end else begin
                st_d.tk = st_q.tk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{com: 2'd0, tk: '0, duty: 2'd3};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        second_half   = (st_q.tk >= TK_HALF);
        in_first_edge = (st_q.com == 2'd0) && !second_half;
        in_last_edge  = (st_q.com == st_q.duty) && second_half;
        com_idx       = st_q.com;
        duty_act      = st_q.duty;
        frame_start   = run && phase0 && (st_q.com == 2'd0) && (st_q.tk == '0);
        irq_set       = run && phase0 && (st_q.com == st_q.duty) && (st_q.tk == TK_HALF);
        fetch_active  = run && !(in_first_edge || in_last_edge);
    end

    // R1: the common index never leaves the active duty range
    a_r1_com_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.com <= st_q.duty));

    // R7: the active duty only ever changes as a frame begins
    a_r7_duty_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(st_q.duty)) |-> (st_q.com == 2'd0 && st_q.tk == '0));

endmodule

// File: rtl/lcdf_level_gen.sv
module lcdf_level_gen
    import lcdf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [1:0]      com_idx,
    input  logic [1:0]      duty_act,
    input  logic            second_half,
    output logic [2*NCOM-1:0] com_level
);

    logic [NCOM-1:0] at_full;

    for (genvar k = 0; k < NCOM; k++) begin : g_com
        lvl_e code;
        always_comb begin
            if (!run || (2'(k) > duty_act)) begin
                code = LV_GND;
            end else if (2'(k) == com_idx) begin
                code = second_half ? LV_GND : LV_FULL;
            end else begin
                code = second_half ? LV_TWO3 : LV_THIRD;
            end
        end
        assign com_level[2*k +: 2] = code;
        assign at_full[k]          = (com_level[2*k +: 2] == LV_FULL);
    end

    // R3: exactly one common is driven to full supply in a first half-period
    a_r3_one_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !second_half) |-> ($countones(at_full) == 1));

endmodule

// File: rtl/lcdf_irq_flag.sv
module lcdf_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    typedef struct packed {
        logic flag;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = set || (st_q.flag && !clr);
        flag      = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: set dominates a simultaneous clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R6: a lone clear drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

    // R6: without a clear the flag holds
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcdf_pkg::*;
#(
    parameter int unsigned PRE_W         = 8,
    parameter int unsigned TICKS_PER_COM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [1:0]         duty_sel,
    input  logic [PRE_W-1:0]   prescale,
    input  logic               irq_clr,
    output logic               frame_start,
    output logic [2*NCOM-1:0]  com_level,
    output logic               fetch_active,
    output logic               write_ok,
    output logic               irq_flag
);

    logic       tick;
    logic       phase0;
    logic [1:0] com_idx;
    logic [1:0] duty_act;
    logic       second_half;
    logic       irq_set;

    lcdf_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .limit  (prescale),
        .tick   (tick),
        .phase0 (phase0)
    );

    lcdf_sequencer #(.TICKS_PER_COM(TICKS_PER_COM)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run_en),
        .tick         (tick),
        .phase0       (phase0),
        .duty_sel     (duty_sel),
        .com_idx      (com_idx),
        .duty_act     (duty_act),
        .second_half  (second_half),
        .frame_start  (frame_start),
        .irq_set      (irq_set),
        .fetch_active (fetch_active)
    );

    lcdf_level_gen u_lvl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_en),
        .com_idx     (com_idx),
        .duty_act    (duty_act),
        .second_half (second_half),
        .com_level   (com_level)
    );

    lcdf_irq_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .flag  (irq_flag)
    );

    assign write_ok = !fetch_active;

    // R4: the end of the read window sets the flag on the next clock
    a_r4_flag_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $fell(fetch_active)) |=> irq_flag);

    // R8: idle outputs while disabled
    a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (write_ok && !fetch_active && !frame_start && com_level == '0));

endmodule

// File: tb/lcd_frame_timer_bench.sv
module lcd_frame_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 8;
    localparam int T          = 4;
    localparam int H          = T / 2;

    localparam int K_WOFF  = 0;
    localparam int K_IOFF  = 1;
    localparam int K_FRAME = 2;
    localparam int K_WIN   = 3;

    typedef struct {
        int kind;
        int val;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic [1:0]       duty_sel = 2'd0;
    logic [PRE_W-1:0] prescale = '0;
    logic             irq_clr = 1'b0;
    logic             frame_start;
    logic [7:0]       com_level;
    logic             fetch_active;
    logic             write_ok;
    logic             irq_flag;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    exp_t exp_q[$];
    logic [3:0] watch = 4'hF;
    bit   arm = 0, mon_on = 0, wr_valid = 0;
    int   last_fs = 0, t_wr = 0;
    logic p_wok = 1'b1, p_irq = 1'b0;

    lcd_frame_timer #(.PRE_W(PRE_W), .TICKS_PER_COM(T)) u_lcd_frame_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .duty_sel     (duty_sel),
        .prescale     (prescale),
        .irq_clr      (irq_clr),
        .frame_start  (frame_start),
        .com_level    (com_level),
        .fetch_active (fetch_active),
        .write_ok     (write_ok),
        .irq_flag     (irq_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic string kind_req(input int k);
        case (k)
            K_WOFF:  return "R5 window open offset";
            K_IOFF:  return "R4 interrupt offset";
            K_FRAME: return "R1 R2 frame length";
            default: return "R5 window length";
        endcase
    endfunction

    // scoreboard compare: pops the oldest expected item of a watched kind
    task automatic sb_check(input int kind, input int val);
        exp_t e;
        if (!watch[kind] || exp_q.size() == 0) return;
        e = exp_q.pop_front();
        check(e.kind == kind, "scoreboard order", kind, e.kind);
        check(e.val == val, kind_req(e.kind), val, e.val);
    endtask

    // monitor
    always @(negedge clk) begin
        if (arm && frame_start) begin
            mon_on   = 1;
            arm      = 0;
            last_fs  = cyc;
            wr_valid = 0;
        end else if (mon_on) begin
            if (frame_start) begin
                sb_check(K_FRAME, cyc - last_fs);
                last_fs = cyc;
            end
            if (write_ok && !p_wok) begin
                sb_check(K_WOFF, cyc - last_fs);
                t_wr     = cyc;
                wr_valid = 1;
            end
            if (!write_ok && p_wok && wr_valid) sb_check(K_WIN, cyc - t_wr);
            if (irq_flag && !p_irq) sb_check(K_IOFF, cyc - last_fs);
        end
        p_wok = write_ok;
        p_irq = irq_flag;
    end

    task automatic push(input int kind, input int val);
        exp_t e;
        e.kind = kind;
        e.val  = val;
        exp_q.push_back(e);
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1 irq_clr = 1'b1;
        @(posedge clk); #1 irq_clr = 1'b0;
    endtask

    task automatic go_idle();
        mon_on = 0;
        @(posedge clk); #1 run_en = 1'b0;
        pulse_clr();
    endtask

    // drain the queue, clearing the flag at each frame start
    task automatic drain();
        while (exp_q.size() != 0) begin
            @(negedge clk);
            if (frame_start) pulse_clr();
        end
    endtask

    // driver: one duty/prescale pairing over two frames
    task automatic run_mode(input int m, input int p);
        int n = m + 1;
        int a = ((n - 1) * T + H) * (p + 1);
        int f = n * T * (p + 1);
        go_idle();
        duty_sel = 2'(m);
        prescale = PRE_W'(p);
        watch    = 4'hF;
        for (int fr = 0; fr < 2; fr++) begin
            if (m != 0) push(K_WOFF, a);
            push(K_IOFF, a + 1);
            push(K_FRAME, f);
            if (m != 0 && fr == 0) push(K_WIN, T * (p + 1));
        end
        arm = 1;
        @(posedge clk); #1 run_en = 1'b1;
        drain();
    endtask

    task automatic check_levels(input int m, input int p);
        go_idle();
        duty_sel = 2'(m);
        prescale = PRE_W'(p);
        @(posedge clk); #1 run_en = 1'b1;
        @(negedge clk);
        check(frame_start == 1'b1, "R8 frame starts with enable", frame_start, 1);
        case (m)
            3: check(com_level == 8'b01_01_01_11, "R3 quarter first half", com_level, 8'b01_01_01_11);
            1: check(com_level == 8'b00_00_01_11, "R3 half duty first half", com_level, 8'b00_00_01_11);
            default: check(com_level == 8'b00_00_00_11, "R3 static first half", com_level, 8'b00_00_00_11);
        endcase
        repeat (H * (p + 1)) @(negedge clk);
        case (m)
            3: check(com_level == 8'b10_10_10_00, "R3 quarter second half", com_level, 8'b10_10_10_00);
            1: check(com_level == 8'b00_00_10_00, "R3 half duty second half", com_level, 8'b00_00_10_00);
            default: check(com_level == 8'b00_00_00_00, "R3 static second half", com_level, 8'b00_00_00_00);
        endcase
        if (m == 3) begin
            repeat (H * (p + 1)) @(negedge clk);
            check(com_level == 8'b01_01_11_01, "R3 quarter common 1", com_level, 8'b01_01_11_01);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(irq_flag == 1'b0, "R9 flag after reset", irq_flag, 0);
        check(com_level == 8'h00, "R8 levels while idle in reset", com_level, 0);
        check(write_ok == 1'b1, "R8 write_ok while idle in reset", write_ok, 1);
        @(posedge clk); #1 rst_n = 1'b1;

        // R3 level patterns
        check_levels(3, 1);
        check_levels(1, 0);
        check_levels(0, 2);

        // R1 R2 R4 R5 timing for every duty setting
        run_mode(3, 1);
        run_mode(2, 0);
        run_mode(1, 3);
        run_mode(0, 2);

        // R7: duty change mid-frame applies at the next boundary
        go_idle();
        duty_sel = 2'd3;
        prescale = '0;
        watch    = 4'b0100;
        push(K_FRAME, 4 * T);
        push(K_FRAME, 2 * T);
        push(K_FRAME, 2 * T);
        arm = 1;
        @(posedge clk); #1 run_en = 1'b1;
        repeat (6) @(posedge clk);
        #1 duty_sel = 2'd1;
        drain();
        @(negedge clk);
        while (!frame_start) @(negedge clk);
        check(com_level == 8'b00_00_01_11, "R7 new duty levels", com_level, 8'b00_00_01_11);

        // R6: set and clear in the same clock leave the flag set
        go_idle();
        duty_sel = 2'd2;
        prescale = PRE_W'(2);
        @(posedge clk); #1 run_en = 1'b1;
        @(negedge clk);
        while (!frame_start) @(negedge clk);
        while (!frame_start) @(negedge clk);
        @(negedge clk);
        while (!frame_start) @(negedge clk);
        check(irq_flag == 1'b1, "R6 flag sticky across frames", irq_flag, 1);
        repeat ((2 * T + H) * 3) @(posedge clk);
        #1 irq_clr = 1'b1;
        @(posedge clk); #1 irq_clr = 1'b0;
        @(negedge clk);
        check(irq_flag == 1'b1, "R6 set wins over clear", irq_flag, 1);
        pulse_clr();
        @(negedge clk);
        check(irq_flag == 1'b0, "R6 lone clear", irq_flag, 0);
        @(negedge clk);
        while (!irq_flag) @(negedge clk);

        // R8: disabled hold
        begin
            bit saw_fs = 0;
            bit bad_lv = 0;
            @(posedge clk); #1 run_en = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (frame_start) saw_fs = 1;
                if (com_level != 8'h00 || !write_ok || fetch_active) bad_lv = 1;
            end
            check(!saw_fs, "R8 no frame start while idle", saw_fs, 0);
            check(!bad_lv, "R8 idle outputs", bad_lv, 0);
            check(irq_flag == 1'b1, "R8 flag kept while idle", irq_flag, 1);
        end

        check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule